// File: doc/BRIEF.md
# Interval Trigger Generator

This block produces a periodic trigger for a digital-to-analog converter. A start event restarts a 16-bit interval counter from zero. The start event is either a rising edge on the start source or a one-cycle software start pulse. From then on the counter advances once per prescaled tick. Each time it reaches the programmed interval, the block emits a one-cycle trigger and reloads the counter to zero. Triggers therefore repeat every interval+1 ticks until the next start event restarts the sequence.

A mode input switches to a bypass path. In that mode the counter is held at zero, and each rising edge on an external trigger input is passed to the output as a one-cycle pulse. An enable input gates all output. While the enable is low, the counter is held at zero and nothing is emitted.

Top module: `intv_trig_gen`

## Requirements
- R1: After reset, `trig_out` is 0 and `count` is 0.
- R2: While `ena` is 0, `trig_out` stays 0 and `count` is held at 0, whatever the start and external inputs do.
- R3: In counter mode (`ext_mode`=0), either of two start events sets `count` to 0 on the next clock edge and starts counting. One start event is a clock edge at which `start_src` is 1 after having been 0 at the previous edge. The other is `sw_start`=1 at a clock edge. A `start_src` that stays high does not restart the counter again.
- R4: While counting, a tick at which `count` is greater than or equal to `interval` produces a `trig_out` pulse one clock later and reloads `count` to 0. Triggers thus repeat every `interval`+1 ticks, and each pulse is one clock wide when `interval` > 0.
- R5: `count` advances only at clock edges where `tick` is 1. Without ticks it holds its value.
- R6: With `ext_mode`=1, a rising edge of `ext_in` sampled at a clock edge makes `trig_out` high for exactly that one clock. `count` is held at 0 in this mode.
- R7: With `interval`=0, a trigger is emitted on every tick.
- R8: A start event while counting restarts the interval from 0, so the next trigger comes `interval`+1 ticks after the restart.
- R9: After reset and before any start event, `count` stays 0 and no trigger is emitted, even with ticks present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Enable for all interval trigger output |
| ext_mode | input | 1 | 1 selects the external bypass path |
| tick | input | 1 | Prescaled count enable |
| start_src | input | 1 | Selected start source, level (rising edge used) |
| sw_start | input | 1 | Software start pulse |
| ext_in | input | 1 | External trigger input (rising edge used) |
| interval | input | 16 | Interval value |
| trig_out | output | 1 | One-cycle trigger pulse |
| count | output | 16 | Current interval counter value |

## Verification
The hardest situation to reach is a restart that lands in the middle of a running interval. A stale count left by that restart would only delay a trigger by a few cycles. The bench lets the counter run partway through an interval and then issues a start. It then times the next trigger against interval+1. It also holds `start_src` high across several periods, so that a design which restarts on the level instead of the edge would shift every later trigger. Sparse ticks (one every other clock) stretch the period, which separates counting on ticks from counting on clocks.

// File: rtl/intv_trig_gen.sv
module intv_trig_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ena,
  input  logic         ext_mode,
  input  logic         tick,
  input  logic         start_src,
  input  logic         sw_start,
  input  logic         ext_in,
  input  logic [W-1:0] interval,
  output logic         trig_out,
  output logic [W-1:0] count
);

  logic src_q, ext_q, running;
  logic [W-1:0] cnt_q;

  wire cnt_mode = ena && !ext_mode;
  wire start    = (start_src && !src_q) || sw_start;
  wire ext_rise = ext_in && !ext_q;
  wire hit      = running && tick && (cnt_q >= interval) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      src_q <= start_src;
      ext_q <= ext_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      running <= 1'b0;
    end else if (!cnt_mode) begin
      cnt_q   <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt_q   <= '0;
      running <= 1'b1;
    end else if (running && tick) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= ena && (ext_mode ? ext_rise : hit);
  end

  assign count = cnt_q;

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> (!trig_out && count == '0)); // R2
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && start) |=> (count == '0 && !trig_out)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && running && tick && !start && count >= interval) |=> (trig_out && count == '0)); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && !tick && !start) |=> $stable(count)); // R5
  AST_EXT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && ext_mode) |=> (count == '0)); // R6

endmodule

// File: tb/sim_intv_trig_gen.sv
module sim_intv_trig_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ena = 0, ext_mode = 0, tick = 0, start_src = 0, sw_start = 0, ext_in = 0;
  logic [15:0] interval = 0;
  logic trig_out;
  logic [15:0] count;
  logic tick_slow = 0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (tick_slow) tick <= ~tick;

  intv_trig_gen u0 (.clk(clk), .rst_n(rst_n), .ena(ena), .ext_mode(ext_mode), .tick(tick),
    .start_src(start_src), .sw_start(sw_start), .ext_in(ext_in), .interval(interval),
    .trig_out(trig_out), .count(count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles_to_trig(output int n);
    n = 0;
    while (!trig_out && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_sw;
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic t_reset;
    chk(trig_out == 0, "R1", trig_out, 0);
    chk(count == 0, "R1", count, 0);
  endtask

  task automatic t_idle;
    ena = 1; tick = 1; interval = 2;
    repeat (10) @(negedge clk);
    chk(count == 0 && trig_out == 0, "R9", count, 0);
  endtask

  task automatic t_basic;
    int n;
    interval = 3;
    pulse_sw();
    cycles_to_trig(n);
    chk(n == 4, "R4 first", n, 4);
    @(negedge clk);
    chk(trig_out == 0, "R4 width", trig_out, 0);
    cycles_to_trig(n);
    chk(n == 3, "R4 period", n + 1, 4);
    interval = 6;
    @(negedge clk);
    cycles_to_trig(n);
    chk(n == 6, "R4 period6", n + 1, 7);
  endtask

  task automatic t_retrig;
    int n;
    interval = 8;
    pulse_sw();
    repeat (4) @(negedge clk);
    chk(count == 4, "R8 midcount", count, 4);
    pulse_sw();
    cycles_to_trig(n);
    chk(n == 9, "R8 restart", n, 9);
  endtask

  task automatic t_src_edge;
    int n;
    ena = 0; @(negedge clk); ena = 1;
    interval = 4;
    start_src = 1;
    @(negedge clk);
    cycles_to_trig(n);
    chk(n == 5, "R3 src edge", n, 5);
    @(negedge clk);
    cycles_to_trig(n);
    chk(n == 4, "R3 level no restart", n + 1, 5);
    start_src = 0;
  endtask

  task automatic t_ticks;
    int n;
    interval = 2;
    tick_slow = 1;
    @(negedge clk);
    @(negedge clk);
    while (count == 0 && !trig_out) @(negedge clk);
    cycles_to_trig(n);
    @(negedge clk);
    cycles_to_trig(n);
    chk(n == 5, "R5 slow period", n + 1, 6);
    tick_slow = 0;
    @(negedge clk);
    tick = 0;
    pulse_sw();
    repeat (5) @(negedge clk);
    chk(count == 0 && trig_out == 0, "R5 no tick hold", count, 0);
    tick = 1;
  endtask

  task automatic t_zero;
    interval = 0;
    pulse_sw();
    @(negedge clk);
    chk(trig_out == 1, "R7 a", trig_out, 1);
    @(negedge clk);
    chk(trig_out == 1, "R7 b", trig_out, 1);
  endtask

  task automatic t_ext;
    ext_mode = 1; interval = 3;
    @(negedge clk);
    chk(count == 0, "R6 count held", count, 0);
    ext_in = 1;
    @(negedge clk);
    chk(trig_out == 1, "R6 pulse", trig_out, 1);
    @(negedge clk);
    chk(trig_out == 0, "R6 single", trig_out, 0);
    pulse_sw();
    repeat (6) @(negedge clk);
    chk(trig_out == 0 && count == 0, "R6 no counting", count, 0);
    ext_in = 0;
    @(negedge clk);
  endtask

  task automatic t_disabled;
    int seen = 0;
    ena = 0;
    ext_in = 1;
    @(negedge clk);
    if (trig_out) seen++;
    ext_in = 0; ext_mode = 0; interval = 1;
    pulse_sw();
    repeat (6) begin
      if (trig_out) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R2 no pulses", seen, 0);
    chk(count == 0, "R2 count held", count, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_retrig();
        t_src_edge();
        t_ticks();
        t_zero();
        t_ext();
        t_disabled();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule